// File: doc/BRIEF.md
# Compact Stack Bytecode Executor

This block is a small multi-cycle processor that runs programs written in a compact stack-oriented bytecode. A program of up to 256 bytes is written into an internal program store through a byte-wide load port. A one-cycle start strobe then runs it from address 0. Instructions move 32-bit values between an internal 16-entry operand stack and a separate array of 256 local words. They add and subtract on the stack, increment locals in place, branch on a negative value and jump. A return instruction ends the run and raises a done flag.

An illegal opcode, a pop from an empty stack or a push onto a full stack stops the machine and raises an error flag instead. Any local word can be observed at any time through a combinational view port. A host therefore loads a program, pulses start, waits for done or error, and reads back the locals it cares about.

Each instruction takes one fetch cycle and one execute cycle. Instructions that carry an operand byte take one more cycle to read it. All branch and jump operands are absolute byte addresses in the program store.

Top module: `sbx_core`

## Requirements
- R1: After reset, done and error are both 0. A start pulse, in any state, clears done and error, empties the operand stack and begins fetching at program address 0, so running the same program twice gives the same result.
- R2: Opcode 0x10 (two bytes) pushes its operand byte sign-extended to 32 bits. Opcode 0x36 (two bytes) pops the top of stack into the local whose address is the operand byte.
- R3: Opcode 0x15 (two bytes) pushes the local at the operand address. Opcode 0x84 (two bytes) adds one to the local at the operand address and leaves the stack unchanged.
- R4: Opcode 0x60 (one byte) replaces the two top entries with their sum. Opcode 0x64 (one byte) replaces them with the lower entry minus the top entry. Both wrap modulo 2^32.
- R5: Opcode 0x9B (two bytes) pops one value. Execution continues at the operand address when bit 31 of that value is 1, and at the next instruction otherwise.
- R6: Opcode 0xA7 (two bytes) continues execution at the absolute operand address.
- R7: Opcode 0xAC (one byte) stops the machine with done set to 1. Done stays 1 until the next start.
- R8: A push when 16 entries are held stops the machine with error set to 1. No later instruction of that run executes. Sixteen pushes alone are legal.
- R9: A pop-type instruction (0x36, 0x9B, 0x60, 0x64) that finds too few entries stops the machine with error set to 1.
- R10: Any opcode byte other than the nine listed stops the machine with error set to 1. No later instruction executes.
- R11: Done and error are never 1 together. Error stays 1 until the next start.
- R12: A repeated-addition factorial program leaves n! modulo 2^32 in its result local.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Write strobe for the program store |
| prog_addr | input | 8 | Program store byte address |
| prog_byte | input | 8 | Program byte to write |
| start | input | 1 | One-cycle pulse that begins a run at address 0 |
| done | output | 1 | Run ended by the return opcode |
| err | output | 1 | Run stopped by a fault |
| view_addr | input | 8 | Address of the local to observe |
| view_data | output | 32 | Current value of the selected local |

## Verification
A wrong stack pointer shows up at the ports as a false error on a legal program, or as a wrong value stored into a local. This appears at the first store after the fault, within a few instructions. A wrong program counter or branch decision sends execution down the wrong path, so the bench builds branch programs whose two paths store different constants. A stuck or misdecoded opcode either leaves done low until the run times out or stops with error set. The looping factorial program repeats every instruction class hundreds of times, so a rare fault builds up into a wrong final product.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

    localparam int BYTE_W  = 8;
    localparam int PROG_AW = 8;
    localparam int LOC_AW  = 8;

    typedef enum logic [7:0] {
        OP_PUSHI = 8'h10,
        OP_LOAD  = 8'h15,
        OP_STORE = 8'h36,
        OP_ADD   = 8'h60,
        OP_SUB   = 8'h64,
        OP_INCL  = 8'h84,
        OP_BRNEG = 8'h9B,
        OP_JUMP  = 8'hA7,
        OP_HALT  = 8'hAC
    } opcode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ARG,
        ST_EXEC,
        ST_DONE,
        ST_FAULT
    } state_e;

    typedef enum logic [1:0] {
        SK_HOLD,
        SK_PUSH,
        SK_POP,
        SK_FOLD
    } stk_op_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_INC
    } alu_op_e;

    typedef enum logic [1:0] {
        PSRC_IMM,
        PSRC_LOC,
        PSRC_ALU
    } push_src_e;

    typedef struct packed {
        stk_op_e   stk_op;
        push_src_e push_src;
        alu_op_e   alu_op;
        logic      loc_we;
        logic      loc_from_alu;
        logic      jump;
        logic      finish;
        logic      fault;
    } exec_ctl_t;

    function automatic logic op_known(input logic [7:0] b);
        case (b)
            OP_PUSHI, OP_LOAD, OP_STORE, OP_ADD, OP_SUB,
            OP_INCL, OP_BRNEG, OP_JUMP, OP_HALT: return 1'b1;
            default:                             return 1'b0;
        endcase
    endfunction

    function automatic logic op_has_arg(input logic [7:0] b);
        case (b)
            OP_PUSHI, OP_LOAD, OP_STORE, OP_INCL,
            OP_BRNEG, OP_JUMP: return 1'b1;
            default:           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sbx_ram.sv
module sbx_ram #(
    parameter int AW = 8,
    parameter int DW = 32,
    parameter int NR = 1
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [DW-1:0]          wdata,
    input  logic [NR-1:0][AW-1:0]  raddr,
    output logic [NR-1:0][DW-1:0]  rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar r = 0; r < NR; r++) begin : g_rd
        assign rdata[r] = mem[raddr[r]];
    end
endmodule

// File: rtl/sbx_opstack.sv
module sbx_opstack
    import sbx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  stk_op_e       op,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] top,
    output logic [DW-1:0] second,
    output logic [CW-1:0] count
);
    logic [DW-1:0] entries [DEPTH];
    logic [IW-1:0] idx_new, idx_top, idx_sec;
    logic          wr_en;
    logic [IW-1:0] wr_idx;

    assign idx_new = IW'(count);
    assign idx_top = IW'(count - CW'(1));
    assign idx_sec = IW'(count - CW'(2));

    assign top    = entries[idx_top];
    assign second = entries[idx_sec];

    always_comb begin
        wr_en  = 1'b0;
        wr_idx = idx_new;
        if (!clear) begin
            case (op)
                SK_PUSH: begin wr_en = 1'b1; wr_idx = idx_new; end
                SK_FOLD: begin wr_en = 1'b1; wr_idx = idx_sec; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) entries[wr_idx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else begin
            case (op)
                SK_PUSH:         count <= count + CW'(1);
                SK_POP, SK_FOLD: count <= count - CW'(1);
                default:         ;
            endcase
        end
    end
endmodule

// File: rtl/sbx_alu.sv
module sbx_alu
    import sbx_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_INC: y = a + DW'(1);
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/sbx_core.sv
module sbx_core
    import sbx_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int STACK_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic [7:0]        prog_addr,
    input  logic [7:0]        prog_byte,
    input  logic              start,
    output logic              done,
    output logic              err,
    input  logic [7:0]        view_addr,
    output logic [DATA_W-1:0] view_data
);
    localparam int STK_CW = $clog2(STACK_DEPTH + 1);

    state_e              state;
    logic [PROG_AW-1:0]  pc;
    logic [BYTE_W-1:0]   ir;
    logic [BYTE_W-1:0]   arg;
    logic [BYTE_W-1:0]   pm_byte;
    exec_ctl_t           ctl;

    logic [DATA_W-1:0]   stk_top, stk_second, stk_wdata;
    logic [STK_CW-1:0]   stk_cnt;
    stk_op_e             stk_op;
    logic                stk_full, stk_has1, stk_has2;

    logic [1:0][DATA_W-1:0] loc_rd;
    logic [DATA_W-1:0]   loc_cur;
    logic [DATA_W-1:0]   loc_wdata;
    logic                loc_we;

    logic [DATA_W-1:0]   alu_a, alu_b, alu_y;
    logic                in_exec;

    // program store: one read port at the program counter
    sbx_ram #(.AW(PROG_AW), .DW(BYTE_W), .NR(1)) u_prog (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_addr),
        .wdata (prog_byte),
        .raddr (pc),
        .rdata (pm_byte)
    );

    // local array: port 0 for execution, port 1 for observation
    sbx_ram #(.AW(LOC_AW), .DW(DATA_W), .NR(2)) u_locals (
        .clk   (clk),
        .we    (loc_we),
        .waddr (arg),
        .wdata (loc_wdata),
        .raddr ({view_addr, arg}),
        .rdata (loc_rd)
    );

    assign loc_cur   = loc_rd[0];
    assign view_data = loc_rd[1];

    sbx_opstack #(.DEPTH(STACK_DEPTH), .DW(DATA_W)) u_stack (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .op     (stk_op),
        .wdata  (stk_wdata),
        .top    (stk_top),
        .second (stk_second),
        .count  (stk_cnt)
    );

    assign stk_full = (stk_cnt == STK_CW'(STACK_DEPTH));
    assign stk_has1 = (stk_cnt != '0);
    assign stk_has2 = (stk_cnt >= STK_CW'(2));

    sbx_alu #(.DW(DATA_W)) u_alu (
        .op (ctl.alu_op),
        .a  (alu_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    assign alu_a = (ctl.alu_op == ALU_INC) ? loc_cur : stk_second;
    assign alu_b = stk_top;

    // instruction decode for the execute cycle
    always_comb begin
        ctl = '{stk_op: SK_HOLD, push_src: PSRC_IMM, alu_op: ALU_ADD,
                loc_we: 1'b0, loc_from_alu: 1'b0, jump: 1'b0,
                finish: 1'b0, fault: 1'b0};
        case (ir)
            OP_PUSHI: begin
                if (stk_full) ctl.fault = 1'b1;
                else begin ctl.stk_op = SK_PUSH; ctl.push_src = PSRC_IMM; end
            end
            OP_LOAD: begin
                if (stk_full) ctl.fault = 1'b1;
                else begin ctl.stk_op = SK_PUSH; ctl.push_src = PSRC_LOC; end
            end
            OP_STORE: begin
                if (!stk_has1) ctl.fault = 1'b1;
                else begin ctl.stk_op = SK_POP; ctl.loc_we = 1'b1; end
            end
            OP_ADD, OP_SUB: begin
                ctl.alu_op = (ir == OP_SUB) ? ALU_SUB : ALU_ADD;
                if (!stk_has2) ctl.fault = 1'b1;
                else begin ctl.stk_op = SK_FOLD; ctl.push_src = PSRC_ALU; end
            end
            OP_BRNEG: begin
                if (!stk_has1) ctl.fault = 1'b1;
                else begin ctl.stk_op = SK_POP; ctl.jump = stk_top[DATA_W-1]; end
            end
            OP_JUMP: ctl.jump = 1'b1;
            OP_INCL: begin
                ctl.alu_op       = ALU_INC;
                ctl.loc_we       = 1'b1;
                ctl.loc_from_alu = 1'b1;
            end
            OP_HALT: ctl.finish = 1'b1;
            default: ctl.fault = 1'b1;
        endcase
    end

    assign in_exec = (state == ST_EXEC) && !start;

    assign stk_op    = in_exec ? ctl.stk_op : SK_HOLD;
    assign loc_we    = in_exec && ctl.loc_we;
    assign loc_wdata = ctl.loc_from_alu ? alu_y : stk_top;

    always_comb begin
        case (ctl.push_src)
            PSRC_LOC: stk_wdata = loc_cur;
            PSRC_ALU: stk_wdata = alu_y;
            default:  stk_wdata = {{(DATA_W-BYTE_W){arg[BYTE_W-1]}}, arg};
        endcase
    end

    // sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pc    <= '0;
            ir    <= '0;
            arg   <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else if (start) begin
            state <= ST_FETCH;
            pc    <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            case (state)
                ST_FETCH: begin
                    ir <= pm_byte;
                    pc <= pc + PROG_AW'(1);
                    if (!op_known(pm_byte)) begin
                        err   <= 1'b1;
                        state <= ST_FAULT;
                    end else if (op_has_arg(pm_byte)) begin
                        state <= ST_ARG;
                    end else begin
                        state <= ST_EXEC;
                    end
                end
                ST_ARG: begin
                    arg   <= pm_byte;
                    pc    <= pc + PROG_AW'(1);
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (ctl.fault) begin
                        err   <= 1'b1;
                        state <= ST_FAULT;
                    end else if (ctl.finish) begin
                        done  <= 1'b1;
                        state <= ST_DONE;
                    end else begin
                        if (ctl.jump) pc <= arg;
                        state <= ST_FETCH;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sbx_core_chk.sv
module sbx_core_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          done,
    input logic          err,
    input logic [CW-1:0] stk_cnt
);
    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    assert_err_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (err && !start) |=> err);

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    assert_start_clears_R1: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && !err && stk_cnt == '0));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        stk_cnt <= CW'(DEPTH));

    assert_stack_step_R8: assert property (@(posedge clk) disable iff (rst)
        !start |=> ({1'b0, stk_cnt} <= {1'b0, $past(stk_cnt)} + (CW+1)'(1)));
endmodule

bind sbx_core sbx_core_chk #(.DEPTH(STACK_DEPTH), .CW(STK_CW)) u_sbx_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .done    (done),
    .err     (err),
    .stk_cnt (stk_cnt)
);

// File: tb/test_sbx_core.sv
module test_sbx_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [7:0]  prog_addr = '0;
    logic [7:0]  prog_byte = '0;
    logic        start = 1'b0;
    logic        done, err;
    logic [7:0]  view_addr = '0;
    logic [31:0] view_data;

    int checks = 0;
    int fails  = 0;

    logic [7:0] img [256];
    int alen;

    always #5 clk = ~clk;

    sbx_core i_sbx_core (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_byte(prog_byte), .start(start), .done(done), .err(err),
        .view_addr(view_addr), .view_data(view_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic a1(input logic [7:0] b);
        img[alen] = b;
        alen++;
    endtask

    task automatic a2(input logic [7:0] op, input logic [7:0] v);
        a1(op);
        a1(v);
    endtask

    task automatic load_img();
        for (int i = 0; i < alen; i++) begin
            @(negedge clk);
            prog_we = 1'b1; prog_addr = 8'(i); prog_byte = img[i];
        end
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic run();
        int cyc;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!(done || err) && cyc < 30000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 30000) chk("run timeout", 32'(cyc), 32'd0);
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        view_addr = a;
        #1;
        v = view_data;
    endtask

    function automatic logic [31:0] sx(input logic [7:0] b);
        return {{24{b[7]}}, b};
    endfunction

    function automatic logic [31:0] fact_ref(input int n);
        logic [31:0] f = 32'd1;
        for (int i = 2; i <= n; i++) f = f * 32'(i);
        return f;
    endfunction

    task automatic build_fact(input logic [7:0] n);
        int loop1, loop2, p1, p2;
        alen = 0;
        a2(8'h10, n);    a2(8'h36, 8'h21);
        a2(8'h10, 8'd1); a2(8'h36, 8'h20);
        a2(8'h10, 8'd2); a2(8'h36, 8'h22);
        loop1 = alen;
        a2(8'h15, 8'h21); a2(8'h15, 8'h22); a1(8'h64);
        p1 = alen + 1; a2(8'h9B, 8'h00);
        a2(8'h10, 8'd0); a2(8'h36, 8'h24);
        a2(8'h10, 8'd1); a2(8'h36, 8'h23);
        loop2 = alen;
        a2(8'h15, 8'h22); a2(8'h15, 8'h23); a1(8'h64);
        p2 = alen + 1; a2(8'h9B, 8'h00);
        a2(8'h15, 8'h24); a2(8'h15, 8'h20); a1(8'h60); a2(8'h36, 8'h24);
        a2(8'h84, 8'h23); a2(8'hA7, 8'(loop2));
        img[p2] = 8'(alen);
        a2(8'h15, 8'h24); a2(8'h36, 8'h20);
        a2(8'h84, 8'h22); a2(8'hA7, 8'(loop1));
        img[p1] = 8'(alen);
        a1(8'hAC);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  a, b;
        int p;
        void'($urandom(32'h5EED));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset done", 32'(done), 32'd0);
        chk("R1 reset err",  32'(err),  32'd0);

        // R2: sign-extended immediate stored to a local
        alen = 0;
        a2(8'h10, 8'hFD); a2(8'h36, 8'h05); a1(8'hAC);
        load_img(); run();
        peek(8'h05, v);
        chk("R2 sext push/store", v, 32'hFFFF_FFFD);
        chk("R7 done after return", 32'(done), 32'd1);
        chk("R11 no err with done", 32'(err), 32'd0);

        // R3 R4: random add/sub, load, increment
        for (int k = 0; k < 10; k++) begin
            a = 8'($urandom);
            b = 8'($urandom);
            if (k == 0) begin a = 8'h80; b = 8'h7F; end
            alen = 0;
            a2(8'h10, a); a2(8'h10, b); a1(8'h64); a2(8'h36, 8'h01);
            a2(8'h10, a); a2(8'h10, b); a1(8'h60); a2(8'h36, 8'h02);
            a2(8'h15, 8'h02); a2(8'h36, 8'h03); a2(8'h84, 8'h03);
            a2(8'h15, 8'h03); a2(8'h36, 8'h04);
            a1(8'hAC);
            load_img(); run();
            peek(8'h01, v); chk("R4 sub lower-minus-top", v, sx(a) - sx(b));
            peek(8'h02, v); chk("R4 add", v, sx(a) + sx(b));
            peek(8'h04, v); chk("R3 load then increment", v, sx(a) + sx(b) + 32'd1);
        end

        // R5: branch on negative, both directions
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: a = 8'hFF;
                1: a = 8'h00;
                2: a = 8'h7F;
                3: a = 8'h80;
                default: a = 8'($urandom);
            endcase
            alen = 0;
            a2(8'h10, a);
            p = alen + 1; a2(8'h9B, 8'h00);
            a2(8'h10, 8'd1); a2(8'h36, 8'h07); a1(8'hAC);
            img[p] = 8'(alen);
            a2(8'h10, 8'd2); a2(8'h36, 8'h07); a1(8'hAC);
            load_img(); run();
            peek(8'h07, v);
            chk("R5 branch if negative", v, a[7] ? 32'd2 : 32'd1);
        end

        // R6: unconditional jump skips a store
        alen = 0;
        a2(8'hA7, 8'd7);
        a2(8'h10, 8'd9); a2(8'h36, 8'h08); a1(8'hAC);
        a2(8'h10, 8'd4); a2(8'h36, 8'h08); a1(8'hAC);
        load_img(); run();
        peek(8'h08, v);
        chk("R6 jump target", v, 32'd4);

        // R8: sixteen pushes are legal; rerun checks R1 stack clearing
        alen = 0;
        for (int k = 0; k < 16; k++) a2(8'h10, 8'(k + 1));
        a2(8'h36, 8'h0C); a1(8'hAC);
        load_img(); run();
        chk("R8 sixteen pushes ok", 32'(err), 32'd0);
        peek(8'h0C, v);
        chk("R8 top after sixteen", v, 32'd16);
        run();
        chk("R1 restart empties stack", {31'd0, done} | {30'd0, err, 1'b0}, 32'd1);

        // R8: seventeenth push faults and nothing after runs
        alen = 0;
        a2(8'h10, 8'd7); a2(8'h36, 8'h09);
        for (int k = 0; k < 17; k++) a2(8'h10, 8'd1);
        a2(8'h10, 8'd5); a2(8'h36, 8'h09); a1(8'hAC);
        load_img(); run();
        chk("R8 overflow err", 32'(err), 32'd1);
        chk("R11 overflow no done", 32'(done), 32'd0);
        repeat (5) @(negedge clk);
        chk("R11 err sticky", 32'(err), 32'd1);
        peek(8'h09, v);
        chk("R8 halted before store", v, 32'd7);

        // R9: pop from empty stack, add with one entry
        alen = 0;
        a2(8'h36, 8'h0B); a1(8'hAC);
        load_img(); run();
        chk("R9 store on empty", 32'(err), 32'd1);
        alen = 0;
        a2(8'h10, 8'd1); a1(8'h60); a1(8'hAC);
        load_img(); run();
        chk("R9 add with one entry", 32'(err), 32'd1);

        // R10: unknown opcode
        alen = 0;
        a2(8'h10, 8'd3); a2(8'h36, 8'h0A); a1(8'h00);
        a2(8'h10, 8'd9); a2(8'h36, 8'h0A); a1(8'hAC);
        load_img(); run();
        chk("R10 unknown opcode err", 32'(err), 32'd1);
        peek(8'h0A, v);
        chk("R10 no execution after", v, 32'd3);

        // R12: factorial by repeated addition
        for (int k = 0; k < 5; k++) begin
            int n;
            case (k)
                0: n = 0;
                1: n = 1;
                2: n = 5;
                3: n = 13;
                default: n = 2 + int'($urandom % 10);
            endcase
            build_fact(8'(n));
            load_img(); run();
            chk("R1 start clears err", 32'(err), 32'd0);
            peek(8'h20, v);
            chk("R12 factorial", v, fact_ref(n));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule